// File: doc/BRIEF.md
# PMP access permission checker

This block decides which of read, write and execute a single memory access may use under physical memory protection. Each cycle it takes the access (start address, byte count, requested privilege bits and whether the hart runs in machine mode), the already-decoded inclusive bounds and the configuration byte of every protection entry, and two security-control bits: a whitelist policy bit and a machine-mode lockdown bit. One clock later it presents a 3-bit granted-privilege mask and an allowed flag.

Entries are searched by index, lowest first. The first active entry that touches the access settles the outcome. If it holds the whole access, its rules grant a mask. If it holds only one end of the access, the access is denied. When no entry is touched, a default applies, chosen by the whitelist bit, the lockdown bit and the mode. Under lockdown, a matched entry's lock, read, write and execute bits form a 4-bit index into one of two fixed grant tables, one for machine mode and one for lower modes. The block does not write the protection registers, decode bounds or interact with a TLB.

Top module: `pmp_perm_check`

## Requirements
- R1: Encodings. A configuration byte holds R in bit 0, W in bit 1, X in bit 2, a 2-bit address mode in bits 4:3 (00 = off), and lock in bit 7. Privilege masks (requested and granted) hold R in bit 0, W in bit 1, X in bit 2. Among active entries that contain both the first and last byte of the access, the lowest-indexed one supplies the grant.
- R2: If the lowest-indexed active entry that contains either end of the access contains only one of them, the result is a granted mask of 000 and a deasserted allowed flag, even when a higher entry covers the whole access.
- R3: An entry whose address mode is 00 is never matched. With no active entry touching the access, the no-match default applies.
- R4: Without lockdown, a matched entry grants 111 to a machine-mode access when its lock bit is clear. Otherwise it grants its own R, W and X bits.
- R5: With lockdown, a matched entry in machine mode uses the index {L,R,W,X}. Indices 0, 1 and 4 to 8 grant 000. Indices 2, 3 and 14 grant RW. Indices 9 and 10 grant X. Indices 11 and 13 grant RX. Indices 12 and 15 grant R.
- R6: With lockdown, a matched entry in a lower mode uses the same index. Indices 0, 8, 9, 12, 13 and 14 grant 000. Indices 1, 10 and 11 grant X. Indices 2, 4 and 15 grant R. Indices 3 and 6 grant RW. Index 5 grants RX. Index 7 grants RWX.
- R7: On no match with the whitelist bit set, the grant is 000 in every mode. This takes precedence over lockdown.
- R8: On no match with lockdown set and the whitelist bit clear, a machine-mode access that does not request X gets RW. Every other access gets 000.
- R9: On no match with both security bits clear, machine mode gets 111 and lower modes get 000. When the protection-present parameter is 0, every mode gets 111.
- R10: The last byte is address + size - 1, computed modulo the address width. A size of 0 counts as 4 bytes.
- R11: The allowed flag is 1 exactly when every requested bit is in the granted mask. Both outputs appear on the clock edge after the inputs, and both are 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | ADDR_W | Byte address of first byte of the access |
| acc_size | input | SIZE_W | Access length in bytes, 0 means 4 |
| acc_req | input | 3 | Requested privileges {X,W,R} |
| acc_mmode | input | 1 | 1 when the access is made in machine mode |
| ent_lo | input | NUM_ENTRIES*ADDR_W | Inclusive lower bound per entry, entry i at slice i |
| ent_hi | input | NUM_ENTRIES*ADDR_W | Inclusive upper bound per entry |
| ent_cfg | input | NUM_ENTRIES*8 | Configuration byte per entry |
| sec_whitelist | input | 1 | Whitelist policy: deny everything on no match |
| sec_lockdown | input | 1 | Machine-mode lockdown: use the 4-bit grant tables |
| res_ok | output | 1 | Access allowed (registered) |
| res_priv | output | 3 | Granted privileges {X,W,R} (registered) |

## Verification
Assertions check on every cycle that the priority selection never picks more than one entry, and that an allowed result never lacks a requested bit. They also check that a straddling hit is always denied, that the whitelist default grants nothing, and that the lockdown default for machine mode follows the execute request. Only the bench scenarios can show that the right entry wins, that both lockdown tables hold their values, that a size of 0 is taken as 4 bytes, and that the defaults for the classic path and the absent-protection build are correct. These all depend on chosen bounds and configuration bytes, which no per-cycle property can predict.

// File: rtl/pmp_perm_pkg.sv
package pmp_perm_pkg;

   localparam int PRIV_W = 3;
   localparam logic [2:0] PV_NONE = 3'b000;
   localparam logic [2:0] PV_R    = 3'b001;
   localparam logic [2:0] PV_X    = 3'b100;
   localparam logic [2:0] PV_RW   = 3'b011;
   localparam logic [2:0] PV_RX   = 3'b101;
   localparam logic [2:0] PV_RWX  = 3'b111;

   typedef struct packed {
      logic       lock;
      logic [1:0] rsvd;
      logic [1:0] amode;
      logic       x;
      logic       w;
      logic       r;
   } ent_cfg_t;

   function automatic logic [3:0] lkd_index(input ent_cfg_t c);
      return {c.lock, c.r, c.w, c.x};
   endfunction

   function automatic logic [2:0] lkd_grant_m(input logic [3:0] idx);
      case (idx)
         4'd2, 4'd3, 4'd14:  return PV_RW;
         4'd9, 4'd10:        return PV_X;
         4'd11, 4'd13:       return PV_RX;
         4'd12, 4'd15:       return PV_R;
         default:            return PV_NONE;
      endcase
   endfunction

   function automatic logic [2:0] lkd_grant_u(input logic [3:0] idx);
      case (idx)
         4'd1, 4'd10, 4'd11: return PV_X;
         4'd2, 4'd4, 4'd15:  return PV_R;
         4'd3, 4'd6:         return PV_RW;
         4'd5:               return PV_RX;
         4'd7:               return PV_RWX;
         default:            return PV_NONE;
      endcase
   endfunction

endpackage

// File: rtl/pmp_range_hit.sv
module pmp_range_hit #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] first_b,
   input  logic [ADDR_W-1:0] last_b,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [7:0]        cfg,
   output logic              full,
   output logic              part
);
   import pmp_perm_pkg::*;

   ent_cfg_t c;
   logic     active, s_in, e_in;

   always_comb begin
      c      = ent_cfg_t'(cfg);
      active = (c.amode != 2'b00);
      s_in   = (first_b >= lo) && (first_b <= hi);
      e_in   = (last_b  >= lo) && (last_b  <= hi);
      full   = active && s_in && e_in;
      part   = active && (s_in ^ e_in);
   end
endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel #(
   parameter int NUM_ENTRIES = 8,
   localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
   input  logic [NUM_ENTRIES-1:0] full,
   input  logic [NUM_ENTRIES-1:0] part,
   output logic [NUM_ENTRIES-1:0] sel,
   output logic [IDX_W-1:0]       sel_idx,
   output logic                   sel_full,
   output logic                   sel_part
);
   logic found;

   always_comb begin
      sel      = '0;
      sel_idx  = '0;
      sel_full = 1'b0;
      sel_part = 1'b0;
      found    = 1'b0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (!found && (full[i] || part[i])) begin
            found    = 1'b1;
            sel[i]   = 1'b1;
            sel_idx  = IDX_W'(i);
            sel_full = full[i];
            sel_part = part[i];
         end
      end
   end
endmodule

// File: rtl/pmp_grant.sv
module pmp_grant #(
   parameter bit PMP_PRESENT = 1'b1
) (
   input  logic [7:0] cfg,
   input  logic       hit_full,
   input  logic       hit_part,
   input  logic       mmode,
   input  logic [2:0] req,
   input  logic       whitelist,
   input  logic       lockdown,
   output logic [2:0] priv,
   output logic       ok
);
   import pmp_perm_pkg::*;

   ent_cfg_t   c;
   logic [2:0] dflt_priv;
   logic       dflt_full;

   generate
      if (PMP_PRESENT) begin : g_present
         assign dflt_full = mmode;
      end else begin : g_absent
         assign dflt_full = 1'b1;
      end
   endgenerate

   always_comb begin
      c = ent_cfg_t'(cfg);
      if (whitelist)
         dflt_priv = PV_NONE;
      else if (lockdown)
         dflt_priv = (mmode && !req[2]) ? PV_RW : PV_NONE;
      else
         dflt_priv = dflt_full ? PV_RWX : PV_NONE;

      if (hit_part)
         priv = PV_NONE;
      else if (hit_full) begin
         if (lockdown)
            priv = mmode ? lkd_grant_m(lkd_index(c)) : lkd_grant_u(lkd_index(c));
         else if (mmode && !c.lock)
            priv = PV_RWX;
         else
            priv = {c.x, c.w, c.r};
      end else
         priv = dflt_priv;

      ok = !hit_part && ((req & ~priv) == 3'b000);
   end
endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check #(
   parameter int NUM_ENTRIES = 8,
   parameter int ADDR_W      = 32,
   parameter int SIZE_W      = 4,
   parameter bit PMP_PRESENT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             acc_addr,
   input  logic [SIZE_W-1:0]             acc_size,
   input  logic [2:0]                    acc_req,
   input  logic                          acc_mmode,
   input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
   input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
   input  logic [NUM_ENTRIES*8-1:0]      ent_cfg,
   input  logic                          sec_whitelist,
   input  logic                          sec_lockdown,
   output logic                          res_ok,
   output logic [2:0]                    res_priv
);
   import pmp_perm_pkg::*;

   localparam int IDX_W = $clog2(NUM_ENTRIES);

   generate
      if (NUM_ENTRIES < 2) begin : g_bad_n
         $error("NUM_ENTRIES must be at least 2");
      end
      if (SIZE_W >= ADDR_W || SIZE_W < 3) begin : g_bad_size
         $error("SIZE_W must be in 3..ADDR_W-1");
      end
   endgenerate

   logic [ADDR_W-1:0]      eff_size, last_b;
   logic [NUM_ENTRIES-1:0] full, part, sel;
   logic [IDX_W-1:0]       sel_idx;
   logic                   sel_full, sel_part;
   logic [7:0]             sel_cfg;
   logic [2:0]             g_priv;
   logic                   g_ok;

   // R10: zero size means a 4-byte access
   assign eff_size = (acc_size == '0) ? ADDR_W'(4) : ADDR_W'(acc_size);
   assign last_b   = acc_addr + eff_size - ADDR_W'(1);

   generate
      for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
         pmp_range_hit #(.ADDR_W(ADDR_W)) u_hit (
            .first_b (acc_addr),
            .last_b  (last_b),
            .lo      (ent_lo[i*ADDR_W +: ADDR_W]),
            .hi      (ent_hi[i*ADDR_W +: ADDR_W]),
            .cfg     (ent_cfg[i*8 +: 8]),
            .full    (full[i]),
            .part    (part[i])
         );
      end
   endgenerate

   pmp_prio_sel #(.NUM_ENTRIES(NUM_ENTRIES)) u_sel (
      .full     (full),
      .part     (part),
      .sel      (sel),
      .sel_idx  (sel_idx),
      .sel_full (sel_full),
      .sel_part (sel_part)
   );

   assign sel_cfg = ent_cfg[sel_idx*8 +: 8];

   pmp_grant #(.PMP_PRESENT(PMP_PRESENT)) u_grant (
      .cfg       (sel_cfg),
      .hit_full  (sel_full),
      .hit_part  (sel_part),
      .mmode     (acc_mmode),
      .req       (acc_req),
      .whitelist (sec_whitelist),
      .lockdown  (sec_lockdown),
      .priv      (g_priv),
      .ok        (g_ok)
   );

   // R11: one-cycle registered result, cleared by reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_ok   <= 1'b0;
         res_priv <= PV_NONE;
      end else begin
         res_ok   <= g_ok;
         res_priv <= g_priv;
      end
   end

   // R1
   one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   // R11
   ok_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_ok |-> ((res_priv & ~$past(acc_req)) != 3'b000 || 1'b1) && ((~res_priv & $past(acc_req)) == 3'b000));

   // R2
   straddle_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_part |=> (!res_ok && res_priv == PV_NONE));

   // R7
   whitelist_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_whitelist && sel == '0) |=> (res_priv == PV_NONE));

   // R8
   lockdown_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_lockdown && !sec_whitelist && sel == '0 && acc_mmode)
      |=> (res_priv == ($past(acc_req[2]) ? PV_NONE : PV_RW)));
endmodule

// File: tb/tb_pmp_perm_check.sv
module tb_pmp_perm_check;
   localparam int N = 8;
   localparam int AW = 32;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [SW-1:0] acc_size = '0;
   logic [2:0]    acc_req = '0;
   logic          acc_mmode = 1'b0;
   logic [N*AW-1:0] ent_lo = '0, ent_hi = '0;
   logic [N*8-1:0]  ent_cfg = '0;
   logic          sec_whitelist = 1'b0, sec_lockdown = 1'b0;
   logic          res_ok, ok2;
   logic [2:0]    res_priv, priv2;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pmp_perm_check #(.NUM_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW)) dut (
      .clk, .rst_n, .acc_addr, .acc_size, .acc_req, .acc_mmode,
      .ent_lo, .ent_hi, .ent_cfg, .sec_whitelist, .sec_lockdown,
      .res_ok, .res_priv);

   pmp_perm_check #(.NUM_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW), .PMP_PRESENT(1'b0)) dut_nopmp (
      .clk, .rst_n, .acc_addr, .acc_size, .acc_req, .acc_mmode,
      .ent_lo, .ent_hi, .ent_cfg, .sec_whitelist, .sec_lockdown,
      .res_ok(ok2), .res_priv(priv2));

   task automatic chk(input string tag, input logic a_ok, input logic [2:0] a_pv,
                      input logic e_ok, input logic [2:0] e_pv);
      n_run++;
      if (a_ok !== e_ok || a_pv !== e_pv) begin
         n_fail++;
         $display("FAIL %s: ok=%0b priv=%03b expected ok=%0b priv=%03b", tag, a_ok, a_pv, e_ok, e_pv);
      end
   endtask

   task automatic set_ent(input int i, input logic [AW-1:0] lo, input logic [AW-1:0] hi, input logic [7:0] cfg);
      ent_lo[i*AW +: AW] = lo;
      ent_hi[i*AW +: AW] = hi;
      ent_cfg[i*8 +: 8]  = cfg;
   endtask

   // drive at a falling edge, result registered on the next rising edge, sample at the next falling edge
   task automatic access(input logic [AW-1:0] a, input logic [SW-1:0] s, input logic [2:0] rq, input logic mm);
      acc_addr = a; acc_size = s; acc_req = rq; acc_mmode = mm;
      @(negedge clk);
   endtask

   task automatic base_map();
      ent_cfg = '0;
      set_ent(0, 32'h100, 32'h1FF, 8'h09);  // mode 01, R
      set_ent(1, 32'h000, 32'hFFF, 8'h0F);  // mode 01, RWX
      sec_whitelist = 1'b0; sec_lockdown = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11 reset", res_ok, res_priv, 1'b0, 3'b000);
   endtask

   task automatic t_priority();
      base_map();
      access(32'h100, 4'd4, 3'b001, 1'b0); chk("R1 low entry read", res_ok, res_priv, 1'b1, 3'b001);
      access(32'h100, 4'd4, 3'b010, 1'b0); chk("R1 low entry write", res_ok, res_priv, 1'b0, 3'b001);
      access(32'h200, 4'd4, 3'b010, 1'b0); chk("R1 second entry", res_ok, res_priv, 1'b1, 3'b111);
      access(32'h080, 4'd8, 3'b101, 1'b0); chk("R11 multi-bit request", res_ok, res_priv, 1'b1, 3'b111);
   endtask

   task automatic t_straddle();
      base_map();
      access(32'h1FE, 4'd4, 3'b001, 1'b0); chk("R2 straddle high", res_ok, res_priv, 1'b0, 3'b000);
      access(32'h0FF, 4'd2, 3'b001, 1'b1); chk("R2 straddle low mmode", res_ok, res_priv, 1'b0, 3'b000);
   endtask

   task automatic t_size();
      base_map();
      access(32'h1FC, 4'd0, 3'b001, 1'b0); chk("R10 size0 inside", res_ok, res_priv, 1'b1, 3'b001);
      access(32'h1FD, 4'd0, 3'b001, 1'b0); chk("R10 size0 straddle", res_ok, res_priv, 1'b0, 3'b000);
      access(32'h1FF, 4'd1, 3'b001, 1'b0); chk("R10 size1 edge", res_ok, res_priv, 1'b1, 3'b001);
   endtask

   task automatic t_off();
      base_map();
      set_ent(0, 32'h100, 32'h1FF, 8'h01);  // mode off
      set_ent(1, 32'h000, 32'hFFF, 8'h07);  // mode off
      access(32'h100, 4'd4, 3'b001, 1'b0); chk("R3 off lower", res_ok, res_priv, 1'b0, 3'b000);
      access(32'h100, 4'd4, 3'b001, 1'b1); chk("R3 off mmode", res_ok, res_priv, 1'b1, 3'b111);
   endtask

   task automatic t_classic();
      base_map();
      access(32'h100, 4'd4, 3'b010, 1'b1); chk("R4 mmode unlocked", res_ok, res_priv, 1'b1, 3'b111);
      set_ent(0, 32'h100, 32'h1FF, 8'h89);
      access(32'h100, 4'd4, 3'b010, 1'b1); chk("R4 mmode locked", res_ok, res_priv, 1'b0, 3'b001);
      access(32'h100, 4'd4, 3'b001, 1'b0); chk("R4 lower locked", res_ok, res_priv, 1'b1, 3'b001);
   endtask

   task automatic lk(input string tag, input logic [7:0] cfg, input logic mm, input logic [2:0] e_pv);
      set_ent(0, 32'h100, 32'h1FF, cfg);
      access(32'h100, 4'd4, 3'b000, mm);
      chk(tag, res_ok, res_priv, 1'b1, e_pv);
   endtask

   task automatic t_lock_m();
      base_map(); sec_lockdown = 1'b1;
      lk("R5 idx14", 8'h8B, 1'b1, 3'b011);
      lk("R5 idx9",  8'h8C, 1'b1, 3'b100);
      lk("R5 idx5",  8'h0D, 1'b1, 3'b000);
      lk("R5 idx12", 8'h89, 1'b1, 3'b001);
      lk("R5 idx11", 8'h8E, 1'b1, 3'b101);
      lk("R5 idx2",  8'h0A, 1'b1, 3'b011);
   endtask

   task automatic t_lock_u();
      base_map(); sec_lockdown = 1'b1;
      lk("R6 idx7",  8'h0F, 1'b0, 3'b111);
      lk("R6 idx1",  8'h0C, 1'b0, 3'b100);
      lk("R6 idx14", 8'h8B, 1'b0, 3'b000);
      lk("R6 idx15", 8'h8F, 1'b0, 3'b001);
      lk("R6 idx6",  8'h0B, 1'b0, 3'b011);
      lk("R6 idx5",  8'h0D, 1'b0, 3'b101);
   endtask

   task automatic t_whitelist();
      base_map(); sec_whitelist = 1'b1; sec_lockdown = 1'b1;
      access(32'h2000, 4'd4, 3'b001, 1'b1); chk("R7 nomatch mmode", res_ok, res_priv, 1'b0, 3'b000);
      access(32'h0200, 4'd4, 3'b001, 1'b0); chk("R7 match unaffected", res_ok, res_priv, 1'b1, 3'b111);
   endtask

   task automatic t_lock_dflt();
      base_map(); sec_lockdown = 1'b1;
      access(32'h2000, 4'd4, 3'b011, 1'b1); chk("R8 mmode rw", res_ok, res_priv, 1'b1, 3'b011);
      access(32'h2000, 4'd4, 3'b100, 1'b1); chk("R8 mmode exec", res_ok, res_priv, 1'b0, 3'b000);
      access(32'h2000, 4'd4, 3'b001, 1'b0); chk("R8 lower", res_ok, res_priv, 1'b0, 3'b000);
   endtask

   task automatic t_classic_dflt();
      base_map();
      access(32'h2000, 4'd4, 3'b111, 1'b1); chk("R9 mmode", res_ok, res_priv, 1'b1, 3'b111);
      access(32'h2000, 4'd4, 3'b001, 1'b0); chk("R9 lower", res_ok, res_priv, 1'b0, 3'b000);
      chk("R9 absent build lower", ok2, priv2, 1'b1, 3'b111);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_priority();
      t_straddle();
      t_size();
      t_off();
      t_classic();
      t_lock_m();
      t_lock_u();
      t_whitelist();
      t_lock_dflt();
      t_classic_dflt();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule